// File: doc/BRIEF.md
# Nine-Bit Serial Display Word Packer

This block sits in front of an 8-bit SPI shifter that drives a display controller. The controller expects a serial format in which every byte carries a ninth leading bit. That bit selects between a command (0) and a parameter or pixel byte (1). The shifter can only move whole octets. The block therefore tags each incoming byte with its flag to form a 9-bit word, packs eight such words into a 72-bit group, and emits the group as nine bytes, most significant bit first.

A transfer is a run of input beats ended by `in_last`. A command transfer is one byte. It is placed in the last word of its group, after seven all-zero no-op words. A data transfer is any number of bytes, and its final group is filled with zero no-op words after the real data. When pixel data arrive low byte first, `in_swap` makes the block emit the high byte of each pixel first. Long transfers are cut into chunks sized to the downstream buffer, and `out_last` marks the end of each chunk and the end of each transfer.

Top module: `dbi9_spi_packer`

## Requirements
- R1: Each word is 9 bits with the flag as its most significant bit: 0 for a command byte (`in_dc`=0), 1 for a data byte (`in_dc`=1). The remaining 8 bits are the byte.
- R2: Eight words form one 72-bit group. Word 0 occupies bits 71..63, word 1 bits 62..54, and so on. The group is emitted as nine bytes, byte j being bits 71-8j down to 64-8j.
- R3: A command transfer (one beat with `in_dc`=0 and `in_last`=1) yields a group of seven zero words followed by the command word, so the output is eight 0x00 bytes followed by the command byte.
- R4: A data transfer whose length is not a multiple of eight has its last group completed with zero words after the final data word.
- R5: A command request longer than one beat (a command beat with `in_last`=0) is rejected. Every beat up to and including the next beat with `in_last`=1 is accepted and discarded, and no output byte results.
- R6: With `in_swap`=1 on data beats, each pair of input bytes (low byte, then high byte) is emitted as high then low. A trailing unpaired byte is emitted as is. With `in_swap`=0, the order is unchanged.
- R7: `out_last` is 1 only on the ninth byte of a group that either ends a transfer or completes a chunk of max(1, BUF_BYTES/9) groups. The chunk count restarts at each transfer end.
- R8: `out_valid` rises only when a whole group is held. While `out_valid`=1 and `out_ready`=0, `out_data` and `out_last` stay unchanged.
- R9: After reset, `out_valid`=0 and `in_ready`=1.
- R10: Under any pattern of `out_ready` backpressure, no byte is lost, repeated or reordered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Input beat accepted |
| in_data | input | 8 | Command or data byte |
| in_dc | input | 1 | 0 = command, 1 = parameter/pixel data |
| in_last | input | 1 | Final beat of a transfer |
| in_swap | input | 1 | Swap byte pairs of data (16-bit pixels, low byte arriving first) |
| out_valid | output | 1 | Output byte valid |
| out_ready | input | 1 | Shifter takes the byte |
| out_data | output | 8 | Packed output byte |
| out_last | output | 1 | Last byte of a chunk or transfer |

## Verification
On every cycle, the assertions check that output bytes hold still under backpressure, that a command group carries nothing but zeros ahead of its command word, that a data group always begins with a flagged data word, that a rejected request never reaches the packer, and that the word count stays inside a group. The byte-exact packing can only be shown by the bench scenarios, which compare whole transfers against an independent model. Those scenarios cover padding after data, swapping with an odd tail, chunk boundary marking and rejection of long commands, all under random output stalls.

// File: rtl/dbi9_pkg.sv
package dbi9_pkg;
  localparam int BYTE_W      = 8;
  localparam int WORD_W      = BYTE_W + 1;
  localparam int GROUP_WORDS = 8;
  localparam int GROUP_W     = WORD_W * GROUP_WORDS;
  localparam int GROUP_BYTES = GROUP_W / BYTE_W;
  localparam int CNT_W       = $clog2(GROUP_WORDS + 2);
  localparam int IDX_W       = $clog2(GROUP_BYTES);
endpackage

// File: rtl/dbi9_word_former.sv
module dbi9_word_former
  import dbi9_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [BYTE_W-1:0]   in_data,
  input  logic                in_dc,
  input  logic                in_last,
  input  logic                in_swap,
  output logic                w_valid,
  input  logic                w_ready,
  output logic                w_two,
  output logic                w_cmd,
  output logic                w_last,
  output logic [2*WORD_W-1:0] w_bits
);
  logic              reject_q;
  logic              hold_v_q;
  logic [BYTE_W-1:0] hold_q;
  logic              drop;
  logic              capture;

  always_comb begin
    drop    = reject_q || (!in_dc && !in_last);
    capture = 1'b0;
    w_valid = 1'b0;
    w_two   = 1'b0;
    w_cmd   = 1'b0;
    w_last  = in_last;
    w_bits  = '0;
    if (in_valid && !drop) begin
      if (!in_dc) begin
        w_valid = 1'b1;
        w_cmd   = 1'b1;
        w_bits  = {{WORD_W{1'b0}}, 1'b0, in_data};
      end else if (in_swap && !hold_v_q && !in_last) begin
        capture = 1'b1;
      end else if (hold_v_q) begin
        w_valid = 1'b1;
        w_two   = 1'b1;
        w_bits  = {1'b1, in_data, 1'b1, hold_q};
      end else begin
        w_valid = 1'b1;
        w_bits  = {{WORD_W{1'b0}}, 1'b1, in_data};
      end
    end
    in_ready = (drop || capture) ? 1'b1 : w_ready;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reject_q <= 1'b0;
      hold_v_q <= 1'b0;
      hold_q   <= '0;
    end else if (in_valid && in_ready) begin
      if (drop) begin
        reject_q <= !in_last;
      end else if (capture) begin
        hold_v_q <= 1'b1;
        hold_q   <= in_data;
      end else if (w_two) begin
        hold_v_q <= 1'b0;
      end
    end
  end

  AST_REJECT_SILENT: assert property (@(posedge clk) disable iff (rst)
    reject_q |-> !w_valid); // R5
endmodule

// File: rtl/dbi9_group_packer.sv
module dbi9_group_packer
  import dbi9_pkg::*;
#(
  parameter int CHUNK_GROUPS = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                w_valid,
  output logic                w_ready,
  input  logic                w_two,
  input  logic                w_cmd,
  input  logic                w_last,
  input  logic [2*WORD_W-1:0] w_bits,
  output logic                g_valid,
  input  logic                g_ready,
  output logic [GROUP_W-1:0]  g_data,
  output logic                g_last,
  output logic                g_cmd
);
  localparam int GC_W = $clog2(CHUNK_GROUPS + 1);

  logic [GROUP_W-1:0] acc_q;
  logic [CNT_W-1:0]   cnt_q;
  logic [GC_W-1:0]    gcnt_q;
  logic               full_q;
  logic               last_q;
  logic               cmd_q;

  logic [CNT_W-1:0]   sum;
  logic [GROUP_W-1:0] merged;
  logic [GROUP_W-1:0] padded;
  logic               closes;
  logic               chunk_end;
  int                 pad_words;

  always_comb begin
    sum = cnt_q + (w_two ? CNT_W'(2) : CNT_W'(1));
    if (w_two)
      merged = {acc_q[GROUP_W-2*WORD_W-1:0], w_bits};
    else
      merged = {acc_q[GROUP_W-WORD_W-1:0], w_bits[WORD_W-1:0]};
    pad_words = (int'(sum) >= GROUP_WORDS) ? 0 : GROUP_WORDS - int'(sum);
    padded    = merged << (pad_words * WORD_W);
    closes    = (int'(sum) >= GROUP_WORDS) || w_last;
    chunk_end = (gcnt_q == GC_W'(CHUNK_GROUPS - 1));
  end

  assign w_ready = !full_q;
  assign g_valid = full_q;
  assign g_data  = acc_q;
  assign g_last  = last_q;
  assign g_cmd   = cmd_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q  <= '0;
      cnt_q  <= '0;
      gcnt_q <= '0;
      full_q <= 1'b0;
      last_q <= 1'b0;
      cmd_q  <= 1'b0;
    end else begin
      if (g_valid && g_ready)
        full_q <= 1'b0;
      if (w_valid && !full_q) begin
        if (w_cmd) begin
          acc_q  <= GROUP_W'(w_bits[WORD_W-1:0]);
          full_q <= 1'b1;
          last_q <= 1'b1;
          cmd_q  <= 1'b1;
          cnt_q  <= '0;
          gcnt_q <= '0;
        end else if (closes) begin
          acc_q  <= padded;
          full_q <= 1'b1;
          last_q <= w_last || chunk_end;
          cmd_q  <= 1'b0;
          cnt_q  <= '0;
          gcnt_q <= (w_last || chunk_end) ? '0 : gcnt_q + GC_W'(1);
        end else begin
          acc_q <= merged;
          cnt_q <= sum;
        end
      end
    end
  end

  AST_CNT_IN_GROUP: assert property (@(posedge clk) disable iff (rst)
    int'(cnt_q) < GROUP_WORDS); // R2
  AST_CMD_PAD_LEAD: assert property (@(posedge clk) disable iff (rst)
    (g_valid && g_cmd) |-> (g_data[GROUP_W-1:WORD_W] == '0 && !g_data[WORD_W-1])); // R3
  AST_DATA_LEAD_FLAG: assert property (@(posedge clk) disable iff (rst)
    (g_valid && !g_cmd) |-> g_data[GROUP_W-1]); // R1
endmodule

// File: rtl/dbi9_byte_serializer.sv
module dbi9_byte_serializer
  import dbi9_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               g_valid,
  output logic               g_ready,
  input  logic [GROUP_W-1:0] g_data,
  input  logic               g_last,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [BYTE_W-1:0]  out_data,
  output logic               out_last
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(GROUP_BYTES - 1);

  logic [GROUP_W-1:0] sh_q;
  logic [IDX_W-1:0]   idx_q;
  logic               ov_q;
  logic               ol_q;

  assign g_ready   = !ov_q || (out_ready && idx_q == LAST_IDX);
  assign out_valid = ov_q;
  assign out_data  = sh_q[GROUP_W-1 -: BYTE_W];
  assign out_last  = ov_q && ol_q && (idx_q == LAST_IDX);

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q  <= '0;
      idx_q <= '0;
      ov_q  <= 1'b0;
      ol_q  <= 1'b0;
    end else if (g_valid && g_ready) begin
      sh_q  <= g_data;
      idx_q <= '0;
      ov_q  <= 1'b1;
      ol_q  <= g_last;
    end else if (ov_q && out_ready) begin
      if (idx_q == LAST_IDX) begin
        ov_q <= 1'b0;
      end else begin
        sh_q  <= sh_q << BYTE_W;
        idx_q <= idx_q + IDX_W'(1);
      end
    end
  end

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last))); // R8
endmodule

// File: rtl/dbi9_spi_packer.sv
module dbi9_spi_packer
  import dbi9_pkg::*;
#(
  parameter int BUF_BYTES = 36
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic [7:0]  in_data,
  input  logic        in_dc,
  input  logic        in_last,
  input  logic        in_swap,
  output logic        out_valid,
  input  logic        out_ready,
  output logic [7:0]  out_data,
  output logic        out_last
);
  localparam int CHUNK_GROUPS = (BUF_BYTES / GROUP_BYTES < 1) ? 1 : BUF_BYTES / GROUP_BYTES;

  logic                w_valid, w_ready, w_two, w_cmd, w_last;
  logic [2*WORD_W-1:0] w_bits;
  logic                g_valid, g_ready, g_last, g_cmd;
  logic [GROUP_W-1:0]  g_data;

  dbi9_word_former former_i (
    .clk(clk), .rst(rst),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .in_dc(in_dc), .in_last(in_last), .in_swap(in_swap),
    .w_valid(w_valid), .w_ready(w_ready), .w_two(w_two),
    .w_cmd(w_cmd), .w_last(w_last), .w_bits(w_bits)
  );

  dbi9_group_packer #(.CHUNK_GROUPS(CHUNK_GROUPS)) packer_i (
    .clk(clk), .rst(rst),
    .w_valid(w_valid), .w_ready(w_ready), .w_two(w_two),
    .w_cmd(w_cmd), .w_last(w_last), .w_bits(w_bits),
    .g_valid(g_valid), .g_ready(g_ready), .g_data(g_data),
    .g_last(g_last), .g_cmd(g_cmd)
  );

  dbi9_byte_serializer serializer_i (
    .clk(clk), .rst(rst),
    .g_valid(g_valid), .g_ready(g_ready), .g_data(g_data), .g_last(g_last),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_last(out_last)
  );
endmodule

// File: tb/dbi9_spi_packer_tb.sv
module dbi9_spi_packer_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int BUF_BYTES  = 36;
  localparam int GRP_CHUNK  = BUF_BYTES / 9;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0, in_dc = 1'b0, in_last = 1'b0, in_swap = 1'b0;
  logic [7:0] in_data = '0;
  logic in_ready, out_valid, out_last;
  logic out_ready = 1'b0;
  logic [7:0] out_data;

  int n_checks = 0, n_fail = 0, cycles = 0;
  int ready_pct = 75;
  logic [8:0] got[$];
  logic [8:0] exp_q[$];

  dbi9_spi_packer #(.BUF_BYTES(BUF_BYTES)) dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_dc(in_dc), .in_last(in_last), .in_swap(in_swap),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_last(out_last)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual hung run, expected completion");
      finish_run();
    end
  end

  initial begin
    forever begin
      @(negedge clk);
      out_ready = ($urandom % 100) < ready_pct;
      #1;
      if (!rst && out_valid && out_ready) got.push_back({out_last, out_data});
    end
  end

  task automatic check(string req, logic [63:0] act, logic [63:0] expv);
    n_checks++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, expv);
    end
  endtask

  // model: list of 9-bit words -> expected bytes with last marks
  task automatic model_words(logic [8:0] w[$]);
    int ng = (w.size() + 7) / 8;
    for (int g = 0; g < ng; g++) begin
      logic [71:0] grp = '0;
      for (int k = 0; k < 8; k++) begin
        int idx = g * 8 + k;
        grp = {grp[62:0], (idx < w.size()) ? w[idx] : 9'h000};
      end
      for (int j = 0; j < 9; j++) begin
        logic lst = (j == 8) && (((g + 1) % GRP_CHUNK == 0) || g == ng - 1);
        exp_q.push_back({lst, grp[71 - 8*j -: 8]});
      end
    end
  endtask

  task automatic beat(logic dc, logic [7:0] d, logic lst, logic sw);
    @(negedge clk);
    in_valid = 1'b1; in_dc = dc; in_data = d; in_last = lst; in_swap = sw;
    #1;
    while (!in_ready) begin @(negedge clk); #1; end
    @(posedge clk);
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 1'b0; in_last = 1'b0;
  endtask

  task automatic drain_compare(string req, int wait_cycles);
    repeat (wait_cycles) @(negedge clk);
    check({req, " byte count"}, 64'(got.size()), 64'(exp_q.size()));
    if (got.size() == exp_q.size()) begin
      for (int i = 0; i < got.size(); i++)
        if (got[i] !== exp_q[i]) begin
          check({req, " byte content"}, 64'(got[i]), 64'(exp_q[i]));
          break;
        end
    end
    got.delete(); exp_q.delete();
  endtask

  task automatic send_cmd(logic [7:0] c);
    logic [8:0] w[$];
    for (int k = 0; k < 7; k++) w.push_back(9'h000);
    w.push_back({1'b0, c});
    model_words(w);
    beat(1'b0, c, 1'b1, 1'b0);
    idle();
    drain_compare("R1 R3 command", 60);
  endtask

  task automatic send_data(logic [7:0] b[$], logic sw, string req);
    logic [8:0] w[$];
    int n = b.size();
    for (int i = 0; i < n; i++) begin
      if (sw && (i % 2 == 0) && (i + 1 < n)) w.push_back({1'b1, b[i+1]});
      else if (sw && (i % 2 == 1)) w.push_back({1'b1, b[i-1]});
      else w.push_back({1'b1, b[i]});
    end
    model_words(w);
    for (int i = 0; i < n; i++) begin
      beat(1'b1, b[i], i == n - 1, sw);
      if (($urandom % 4) == 0) idle();
    end
    idle();
    drain_compare(req, 40 + 30 * ((n + 7) / 8));
  endtask

  task automatic send_reject(int n);
    for (int i = 0; i < n; i++) beat(1'b0, 8'($urandom), i == n - 1, 1'b0);
    idle();
    drain_compare("R5 rejected long command", 60);
  endtask

  task automatic data_of(int n, output logic [7:0] b[$]);
    b.delete();
    for (int i = 0; i < n; i++) b.push_back(8'($urandom));
  endtask

  initial begin
    logic [7:0] b[$];
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    check("R9 out_valid after reset", 64'(out_valid), 64'd0);
    check("R9 in_ready after reset", 64'(in_ready), 64'd1);

    send_cmd(8'h2c);                               // R3
    data_of(8, b);  send_data(b, 1'b0, "R1 R2 full group");
    data_of(1, b);  send_data(b, 1'b0, "R4 single byte pad");
    data_of(9, b);  send_data(b, 1'b0, "R4 two groups");
    data_of(33, b); send_data(b, 1'b0, "R7 chunk boundary");
    send_reject(3);                                // R5
    send_cmd(8'hb1);
    data_of(5, b);  send_data(b, 1'b1, "R6 swap odd tail");
    data_of(16, b); send_data(b, 1'b1, "R6 swap pixels");
    ready_pct = 25;
    data_of(24, b); send_data(b, 1'b0, "R10 heavy stall");
    ready_pct = 75;

    for (int t = 0; t < 24; t++) begin
      int kind = $urandom % 10;
      if (kind < 2) send_cmd(8'($urandom));
      else if (kind < 3) send_reject(2 + ($urandom % 3));
      else begin
        data_of(1 + ($urandom % 40), b);
        send_data(b, 1'($urandom), "R2 R7 R10 random data");
      end
    end
    finish_run();
  end
endmodule